// File: doc/BRIEF.md
# Refresh and Power-Down Sequencer

This block sits ahead of a DRAM command scheduler and works on timestamps rather than on live clock edges. For each incoming transaction it receives three values: the arrival cycle of the transaction, the end cycle of the previous one, and the cycle of the most recent precharge. From these it decides whether the idle gap is long enough for a low-power interval and whether refresh slots are due. It then emits the resulting commands one per clock, each tagged with the cycle at which it applies. It also keeps a blocking-until cycle that the scheduler must respect before issuing anything further.

A mode input selects refresh only, precharge power-down, or self-refresh. The refresh deadline is kept inside the block. When an idle gap covers several refresh intervals, the block catches up one slot per elapsed interval. A power-down never lasts longer than one refresh interval. While the device is held in self-refresh, explicit refreshes are withheld, but the deadline keeps moving. A scheduler activate, signalled on its own input, ends the self-refresh state. A device-family parameter chooses between the short exit latencies of low-power parts and the DLL-relock latencies of standard parts.

Top module: `rfpd_sequencer`

## Requirements
- R1: After reset, `block_until` is 0, `cmd_valid` is low, `req_ready` is high, and the first refresh deadline is TREFI.
- R2: The idle start is the larger of `req_last_end` and `req_last_pre`+TRP. A refresh slot is taken when the idle start or the arrival has reached the deadline. The slot's cycle is the largest of the idle start, the deadline and `block_until`. A refresh that is emitted uses kind code 1, and `block_until` then becomes its cycle plus TRFC.
- R3: Each slot advances the deadline by TREFI. Further slots follow as long as the advanced deadline is not beyond the arrival, so a long gap produces one slot per elapsed interval.
- R4: Mode 1 (power-down) checks, before any slot, a limit equal to the smaller of the arrival and the deadline. The start is the larger of the idle start and `block_until`. Entry (kind 2, at the start) happens only when the limit exceeds start+TCKE.
- R5: Power-down exit (kind 3) falls at the start plus the smaller of (limit minus start) and TREFI. `block_until` then becomes exit+TXP when LOW_POWER_FAMILY is 1, otherwise exit+TXPDLL-TRCD.
- R6: Mode 2 (self-refresh) checks, before any slot, with the arrival as the limit. Entry (kind 4, at the start) needs the limit to exceed start+TCKESR. Exit (kind 5) falls at the limit. `block_until` then becomes exit+TXS when LOW_POWER_FAMILY is 1, otherwise exit+TXSDLL-TRCD.
- R7: While self-refresh is active, refresh slots emit no command but still advance the deadline, and no low-power check follows them.
- R8: A pulse on `act_issued` clears the self-refresh state. If it coincides with a self-refresh entry, the entry wins.
- R9: Mode 0 (and the unused code 3) never emits a low-power command; only refreshes appear.
- R10: Within one request the order is: the low-power check, then the slots. After each slot that is not suppressed, in a low-power mode, a further check runs with the limit set to the smaller of the arrival and the new deadline. Every entry is followed by its exit in the very next cycle.
- R11: `done` pulses for one cycle after the last command, with `cmd_valid` low. `req_ready` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New transaction timing presented (taken when `req_ready`) |
| req_arrival | input | 32 | Arrival cycle of the new transaction |
| req_last_end | input | 32 | End cycle of the previous transaction |
| req_last_pre | input | 32 | Cycle of the latest precharge |
| req_mode | input | 2 | 0 refresh only, 1 power-down, 2 self-refresh |
| act_issued | input | 1 | Scheduler issued an activate; clears self-refresh state |
| req_ready | output | 1 | Block idle and able to take a request |
| cmd_valid | output | 1 | A command is presented this cycle |
| cmd_kind | output | 3 | 1 refresh, 2/3 power-down entry/exit, 4/5 self-refresh entry/exit |
| cmd_time | output | 32 | Cycle at which the command applies |
| block_until | output | 32 | Scheduler must not issue before this cycle |
| done | output | 1 | Request fully processed |

## Verification
A self-refresh entry and an `act_issued` pulse can land on the same clock edge, one setting and the other clearing the same state. The bench provokes this by watching the outputs for the entry code and raising `act_issued` in exactly that cycle. It then follows up with a refresh-only request whose arrival lies past the deadline. Because the entry wins, that follow-up must show its slots suppressed. The opposite case, a pulse on its own while the block is idle, must let the refreshes through again.

// File: rtl/rfpd_pkg.sv
package rfpd_pkg;

    localparam int TIME_W = 32;

    typedef logic [TIME_W-1:0] rfpd_time_t;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_REF      = 3'd1,
        CMD_PD_ENTER = 3'd2,
        CMD_PD_EXIT  = 3'd3,
        CMD_SR_ENTER = 3'd4,
        CMD_SR_EXIT  = 3'd5
    } rfpd_cmd_e;

    typedef enum logic [1:0] {
        LP_OFF  = 2'd0,
        LP_PDN  = 2'd1,
        LP_SELF = 2'd2,
        LP_RSVD = 2'd3
    } rfpd_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LP_PRE,
        ST_EXIT,
        ST_REF_CHK,
        ST_REF,
        ST_LP_POST,
        ST_DONE
    } rfpd_state_e;

    typedef struct packed {
        logic       enter;
        rfpd_cmd_e  enter_kind;
        rfpd_cmd_e  exit_kind;
        rfpd_time_t start;
        rfpd_time_t exit_t;
        rfpd_time_t resume;
        logic       to_sr;
    } lp_decision_t;

    function automatic rfpd_time_t tmax(input rfpd_time_t a, input rfpd_time_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic rfpd_time_t tmin(input rfpd_time_t a, input rfpd_time_t b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/rfpd_lowpower_eval.sv
module rfpd_lowpower_eval
    import rfpd_pkg::*;
#(
    parameter int TREFI  = 200,
    parameter int TCKE   = 4,
    parameter int TCKESR = 6,
    parameter int PD_LAT = 7,
    parameter int SR_LAT = 55
) (
    input  rfpd_mode_e   mode,
    input  rfpd_time_t   idle_from,
    input  rfpd_time_t   blocked_to,
    input  rfpd_time_t   limit,
    output lp_decision_t dec
);
    localparam rfpd_time_t CKE_T   = rfpd_time_t'(TCKE);
    localparam rfpd_time_t CKESR_T = rfpd_time_t'(TCKESR);
    localparam rfpd_time_t REFI_T  = rfpd_time_t'(TREFI);
    localparam rfpd_time_t PDLAT_T = rfpd_time_t'(PD_LAT);
    localparam rfpd_time_t SRLAT_T = rfpd_time_t'(SR_LAT);

    rfpd_time_t start_t;
    rfpd_time_t span_t;

    always_comb begin
        start_t        = tmax(idle_from, blocked_to);
        span_t         = limit - start_t;
        dec            = '0;
        dec.start      = start_t;
        dec.enter_kind = CMD_NONE;
        dec.exit_kind  = CMD_NONE;
        unique case (mode)
            LP_PDN: begin
                if (limit > start_t + CKE_T) begin
                    dec.enter      = 1'b1;
                    dec.enter_kind = CMD_PD_ENTER;
                    dec.exit_kind  = CMD_PD_EXIT;
                    dec.exit_t     = start_t + tmin(span_t, REFI_T);
                    dec.resume     = start_t + tmin(span_t, REFI_T) + PDLAT_T;
                end
            end
            LP_SELF: begin
                if (limit > start_t + CKESR_T) begin
                    dec.enter      = 1'b1;
                    dec.enter_kind = CMD_SR_ENTER;
                    dec.exit_kind  = CMD_SR_EXIT;
                    dec.exit_t     = limit;
                    dec.resume     = limit + SRLAT_T;
                    dec.to_sr      = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rfpd_refresh_slot.sv
module rfpd_refresh_slot
    import rfpd_pkg::*;
#(
    parameter int TRFC = 30
) (
    input  rfpd_time_t idle_from,
    input  rfpd_time_t deadline,
    input  rfpd_time_t blocked_to,
    output rfpd_time_t slot_t,
    output rfpd_time_t slot_resume
);
    localparam rfpd_time_t RFC_T = rfpd_time_t'(TRFC);

    always_comb begin
        slot_t      = tmax(tmax(idle_from, deadline), blocked_to);
        slot_resume = slot_t + RFC_T;
    end
endmodule

// File: rtl/rfpd_deadline.sv
module rfpd_deadline
    import rfpd_pkg::*;
#(
    parameter int TREFI = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    output rfpd_time_t deadline,
    output rfpd_time_t next_deadline
);
    localparam rfpd_time_t REFI_T = rfpd_time_t'(TREFI);

    assign next_deadline = deadline + REFI_T;

    always_ff @(posedge clk) begin
        if (rst) begin
            deadline <= REFI_T;
        end else if (advance) begin
            deadline <= next_deadline;
        end
    end
endmodule

// File: rtl/rfpd_sequencer.sv
module rfpd_sequencer
    import rfpd_pkg::*;
#(
    parameter int TREFI            = 200,
    parameter int TRFC             = 30,
    parameter int TRP              = 5,
    parameter int TCKE             = 4,
    parameter int TCKESR           = 6,
    parameter int TXP              = 3,
    parameter int TXPDLL           = 12,
    parameter int TRCD             = 5,
    parameter int TXS              = 40,
    parameter int TXSDLL           = 60,
    parameter int LOW_POWER_FAMILY = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_arrival,
    input  logic [31:0] req_last_end,
    input  logic [31:0] req_last_pre,
    input  logic [1:0]  req_mode,
    input  logic        act_issued,
    output logic        req_ready,
    output logic        cmd_valid,
    output logic [2:0]  cmd_kind,
    output logic [31:0] cmd_time,
    output logic [31:0] block_until,
    output logic        done
);
    localparam int PD_LAT = (LOW_POWER_FAMILY != 0) ? TXP : (TXPDLL - TRCD);
    localparam int SR_LAT = (LOW_POWER_FAMILY != 0) ? TXS : (TXSDLL - TRCD);
    localparam rfpd_time_t RP_T = rfpd_time_t'(TRP);

    rfpd_state_e  state, ret_q;
    rfpd_mode_e   mode_q;
    rfpd_time_t   arr_q, idle_q, blk_q;
    rfpd_time_t   pend_time, pend_resume;
    rfpd_cmd_e    pend_kind;
    logic         sr_q, more_q;

    rfpd_time_t   deadline_w, next_deadline_w;
    rfpd_time_t   limit_w, slot_t_w, slot_resume_w;
    lp_decision_t dec_w;
    logic         in_lp_check, refresh_due, more_next;
    rfpd_state_e  after_slot;

    rfpd_deadline #(.TREFI(TREFI)) deadline_i (
        .clk           (clk),
        .rst           (rst),
        .advance       (state == ST_REF),
        .deadline      (deadline_w),
        .next_deadline (next_deadline_w)
    );

    rfpd_lowpower_eval #(
        .TREFI(TREFI), .TCKE(TCKE), .TCKESR(TCKESR),
        .PD_LAT(PD_LAT), .SR_LAT(SR_LAT)
    ) lp_i (
        .mode       (mode_q),
        .idle_from  (idle_q),
        .blocked_to (blk_q),
        .limit      (limit_w),
        .dec        (dec_w)
    );

    rfpd_refresh_slot #(.TRFC(TRFC)) slot_i (
        .idle_from   (idle_q),
        .deadline    (deadline_w),
        .blocked_to  (blk_q),
        .slot_t      (slot_t_w),
        .slot_resume (slot_resume_w)
    );

    always_comb begin
        in_lp_check = (state == ST_LP_PRE) || (state == ST_LP_POST);
        limit_w     = (state == ST_LP_PRE && mode_q == LP_SELF) ? arr_q
                                                                : tmin(arr_q, deadline_w);
        refresh_due = (idle_q >= deadline_w) || (arr_q >= deadline_w);
        more_next   = (next_deadline_w <= arr_q);
        after_slot  = more_q ? ST_REF : ST_DONE;
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_kind  = CMD_NONE;
        cmd_time  = '0;
        unique case (state)
            ST_LP_PRE, ST_LP_POST: begin
                cmd_valid = dec_w.enter;
                cmd_kind  = dec_w.enter ? dec_w.enter_kind : CMD_NONE;
                cmd_time  = dec_w.enter ? dec_w.start : '0;
            end
            ST_EXIT: begin
                cmd_valid = 1'b1;
                cmd_kind  = pend_kind;
                cmd_time  = pend_time;
            end
            ST_REF: begin
                cmd_valid = !sr_q;
                cmd_kind  = sr_q ? CMD_NONE : CMD_REF;
                cmd_time  = sr_q ? '0 : slot_t_w;
            end
            default: ;
        endcase
    end

    assign req_ready   = (state == ST_IDLE);
    assign done        = (state == ST_DONE);
    assign block_until = blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= 1'b0;
        end else if (in_lp_check && dec_w.enter && dec_w.to_sr) begin
            sr_q <= 1'b1;
        end else if (act_issued) begin
            sr_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ret_q       <= ST_IDLE;
            mode_q      <= LP_OFF;
            arr_q       <= '0;
            idle_q      <= '0;
            blk_q       <= '0;
            pend_time   <= '0;
            pend_resume <= '0;
            pend_kind   <= CMD_NONE;
            more_q      <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        arr_q  <= req_arrival;
                        idle_q <= tmax(req_last_end, req_last_pre + RP_T);
                        mode_q <= rfpd_mode_e'(req_mode);
                        state  <= ST_LP_PRE;
                    end
                end
                ST_LP_PRE, ST_LP_POST: begin
                    if (dec_w.enter) begin
                        pend_kind   <= dec_w.exit_kind;
                        pend_time   <= dec_w.exit_t;
                        pend_resume <= dec_w.resume;
                        ret_q       <= (state == ST_LP_PRE) ? ST_REF_CHK : after_slot;
                        state       <= ST_EXIT;
                    end else begin
                        state <= (state == ST_LP_PRE) ? ST_REF_CHK : after_slot;
                    end
                end
                ST_EXIT: begin
                    blk_q <= pend_resume;
                    state <= ret_q;
                end
                ST_REF_CHK: begin
                    state <= refresh_due ? ST_REF : ST_DONE;
                end
                ST_REF: begin
                    if (!sr_q) begin
                        blk_q <= slot_resume_w;
                    end
                    more_q <= more_next;
                    if (!sr_q && mode_q != LP_OFF) begin
                        state <= ST_LP_POST;
                    end else begin
                        state <= more_next ? ST_REF : ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rfpd_sequencer_checker.sv
module rfpd_sequencer_checker
    import rfpd_pkg::*;
#(
    parameter int TREFI = 200,
    parameter int TRFC  = 30
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [2:0]  cmd_kind,
    input logic [31:0] cmd_time,
    input logic [31:0] block_until,
    input logic        done,
    input logic        req_ready,
    input logic        sr_active,
    input logic [31:0] deadline,
    input logic [1:0]  mode_latched
);
    localparam logic [31:0] REFI_V = 32'(TREFI);
    localparam logic [31:0] RFC_V  = 32'(TRFC);

    // R2: an emitted refresh blocks the scheduler for TRFC after its cycle
    assert_ref_block_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == CMD_REF) |=> (block_until == $past(cmd_time) + RFC_V));

    // R3: the deadline only ever moves forward by one interval
    assert_deadline_step_R3: assert property (@(posedge clk) disable iff (rst)
        (deadline != $past(deadline)) |-> (deadline == $past(deadline) + REFI_V));

    // R5: a power-down exit follows its entry by at most one interval
    assert_pd_cap_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == CMD_PD_ENTER) |=>
        (cmd_valid && cmd_kind == CMD_PD_EXIT && (cmd_time - $past(cmd_time)) <= REFI_V));

    // R7: no refresh leaves the block while self-refresh holds
    assert_sr_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        sr_active |-> !(cmd_valid && cmd_kind == CMD_REF));

    // R9: refresh-only mode never emits a low-power command
    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_latched == 2'd0 && cmd_valid) |-> (cmd_kind == CMD_REF));

    // R10: a self-refresh entry is followed at once by its exit
    assert_sr_pair_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == CMD_SR_ENTER) |=> (cmd_valid && cmd_kind == CMD_SR_EXIT));

    // R11: completion carries no command and returns to ready
    assert_done_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (!cmd_valid && !req_ready));

    assert_ready_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);
endmodule

bind rfpd_sequencer rfpd_sequencer_checker #(.TREFI(TREFI), .TRFC(TRFC)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_kind     (cmd_kind),
    .cmd_time     (cmd_time),
    .block_until  (block_until),
    .done         (done),
    .req_ready    (req_ready),
    .sr_active    (sr_q),
    .deadline     (deadline_w),
    .mode_latched (mode_q)
);

// File: tb/rfpd_sequencer_tb.sv
`timescale 1ns/1ps
module rfpd_sequencer_tb_top;

    localparam int TREFI = 200, TRFC = 30, TRP = 5, TCKE = 4, TCKESR = 6;
    localparam int TXP = 3, TXPDLL = 12, TRCD = 5, TXS = 40, TXSDLL = 60;
    localparam int PDL = TXPDLL - TRCD;
    localparam int SRL = TXSDLL - TRCD;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, act_issued;
    logic [31:0] req_arrival, req_last_end, req_last_pre;
    logic [1:0]  req_mode;
    logic        req_ready, cmd_valid, done;
    logic [2:0]  cmd_kind;
    logic [31:0] cmd_time, block_until;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    rfpd_sequencer dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_arrival(req_arrival),
        .req_last_end(req_last_end), .req_last_pre(req_last_pre), .req_mode(req_mode),
        .act_issued(act_issued), .req_ready(req_ready), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_time(cmd_time), .block_until(block_until), .done(done)
    );

    // reference model state
    logic [31:0] m_dl, m_blk;
    bit          m_sr;
    logic [2:0]  exp_k [64];
    logic [31:0] exp_t [64];
    int          exp_n;
    logic [2:0]  got_k [64];
    logic [31:0] got_t [64];
    int          got_n;

    function automatic logic [31:0] mx(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? a : b;
    endfunction
    function automatic logic [31:0] mn(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

    function void push(input logic [2:0] k, input logic [31:0] t);
        if (exp_n < 64) begin
            exp_k[exp_n] = k;
            exp_t[exp_n] = t;
        end
        exp_n++;
    endfunction

    // R4 R5 R6: low-power decision
    function void m_lp(input logic [1:0] md, input logic [31:0] idle, input logic [31:0] lim);
        logic [31:0] st, ex;
        st = mx(idle, m_blk);
        if (md == 2'd1 && lim > st + 32'(TCKE)) begin
            ex = st + mn(lim - st, 32'(TREFI));
            push(3'd2, st);
            push(3'd3, ex);
            m_blk = ex + 32'(PDL);
        end else if (md == 2'd2 && lim > st + 32'(TCKESR)) begin
            push(3'd4, st);
            push(3'd5, lim);
            m_sr  = 1'b1;
            m_blk = lim + 32'(SRL);
        end
    endfunction

    // R2 R3 R7 R10: one request
    function void m_request(input logic [31:0] arr, input logic [31:0] lend,
                            input logic [31:0] lpre, input logic [1:0] md);
        logic [31:0] idle, t;
        bit more;
        exp_n = 0;
        idle  = mx(lend, lpre + 32'(TRP));
        m_lp(md, idle, (md == 2'd2) ? arr : mn(arr, m_dl));
        if (idle >= m_dl || arr >= m_dl) begin
            more = 1'b1;
            while (more) begin
                t = mx(mx(idle, m_dl), m_blk);
                if (!m_sr) begin
                    push(3'd1, t);
                    m_blk = t + 32'(TRFC);
                end
                m_dl = m_dl + 32'(TREFI);
                more = (m_dl <= arr);
                if (!m_sr) m_lp(md, idle, mn(arr, m_dl));
            end
        end
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic act_pulse();
        @(negedge clk);
        act_issued = 1'b1;
        @(negedge clk);
        act_issued = 1'b0;
        m_sr = 1'b0;
    endtask

    task automatic run_req(input logic [31:0] arr, input logic [31:0] lend,
                           input logic [31:0] lpre, input logic [1:0] md,
                           input bit collide, input string tag);
        int cyc;
        m_request(arr, lend, lpre, md);
        @(negedge clk);
        req_valid    = 1'b1;
        req_arrival  = arr;
        req_last_end = lend;
        req_last_pre = lpre;
        req_mode     = md;
        @(negedge clk);
        req_valid = 1'b0;
        got_n = 0;
        cyc   = 0;
        while (1) begin
            act_issued = 1'b0;
            if (cmd_valid) begin
                if (got_n < 64) begin
                    got_k[got_n] = cmd_kind;
                    got_t[got_n] = cmd_time;
                end
                got_n++;
                if (collide && cmd_kind == 3'd4) act_issued = 1'b1;
            end
            if (done) break;
            @(negedge clk);
            cyc++;
            if (cyc > 400) begin
                check(1'b0, tag, "request never completed", 32'(cyc), 32'd0);
                break;
            end
        end
        check(got_n == exp_n, tag, "command count", 32'(got_n), 32'(exp_n));
        for (int i = 0; i < got_n && i < exp_n && i < 64; i++) begin
            check(got_k[i] == exp_k[i], tag, "command kind", 32'(got_k[i]), 32'(exp_k[i]));
            check(got_t[i] == exp_t[i], tag, "command cycle", got_t[i], exp_t[i]);
        end
        check(block_until == m_blk, tag, "block_until", block_until, m_blk);
        @(negedge clk);
        act_issued = 1'b0;
        // R11: back to ready with nothing on the command outputs
        check(req_ready && !cmd_valid && !done, "R11", "ready after done",
              {30'd0, req_ready, cmd_valid}, 32'd2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run timed out", 32'd0, 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lend, lpre, arr, prev;
        logic [1:0]  md;
        void'($urandom(32'd20240611));
        rst = 1'b1; req_valid = 1'b0; act_issued = 1'b0;
        req_arrival = '0; req_last_end = '0; req_last_pre = '0; req_mode = 2'd0;
        m_dl = 32'(TREFI); m_blk = '0; m_sr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(block_until == 0, "R1", "block_until after reset", block_until, 32'd0);
        check(!cmd_valid, "R1", "cmd_valid after reset", {31'd0, cmd_valid}, 32'd0);
        check(req_ready, "R1", "req_ready after reset", {31'd0, req_ready}, 32'd1);

        // R9: refresh-only with short gap, nothing due (R1 first deadline TREFI)
        run_req(32'd50, 32'd10, 32'd8, 2'd0, 1'b0, "R9 R1");
        check(exp_n == 0, "R1", "model expects no slot before TREFI", 32'(exp_n), 32'd0);
        // R2 R3: catch-up across several intervals
        run_req(m_dl + 32'(2*TREFI) + 32'd7, 32'd60, 32'd60, 2'd0, 1'b0, "R2 R3");
        check(exp_n == 3, "R3", "slots for a three-interval gap", 32'(got_n), 32'd3);
        // R4: gap exactly TCKE, no entry; then one more cycle, entry
        lend = m_blk + 32'd5;
        run_req(lend + 32'(TCKE), lend, 32'd0, 2'd1, 1'b0, "R4");
        check(got_n == 0, "R4", "no power-down at threshold", 32'(got_n), 32'd0);
        lend = m_blk + 32'd5;
        run_req(lend + 32'(TCKE) + 32'd1, lend, 32'd0, 2'd1, 1'b0, "R4 R5");
        // R5 R10: power-down with refresh slots in a long gap
        lend = m_blk + 32'd1;
        run_req(m_dl + 32'(3*TREFI), lend, lend, 2'd1, 1'b0, "R5 R10");
        // R6 R7: self-refresh over a long gap suppresses the slots
        lend = m_blk + 32'd2;
        run_req(m_dl + 32'(2*TREFI) + 32'd3, lend, 32'd0, 2'd2, 1'b0, "R6 R7");
        check(got_n == 2, "R7", "only entry and exit under self-refresh", 32'(got_n), 32'd2);
        // R8: an activate pulse releases the state, refreshes resume
        act_pulse();
        lend = m_blk;
        run_req(m_dl + 32'd10, lend, 32'd0, 2'd0, 1'b0, "R8");
        check(got_n >= 1 && got_k[0] == 3'd1, "R8", "refresh after activate", 32'(got_n), 32'd1);
        // R8: activate in the entry cycle; entry wins, next slots stay quiet
        lend = m_blk + 32'd3;
        run_req(lend + 32'd50, lend, 32'd0, 2'd2, 1'b1, "R8 R6");
        run_req(m_dl + 32'd20, m_blk, 32'd0, 2'd0, 1'b0, "R8 R7");
        check(got_n == 0, "R8", "slots suppressed after same-cycle activate", 32'(got_n), 32'd0);
        act_pulse();

        // random phase
        prev = m_blk;
        for (int r = 0; r < 80; r++) begin
            if ($urandom % 4 == 0) act_pulse();
            md   = 2'($urandom % 4);
            lend = mx(prev, m_blk) + 32'($urandom % 50);
            lpre = (lend > 32'd20) ? lend - 32'($urandom % 20) : lend;
            arr  = lend + 32'($urandom % 650);
            run_req(arr, lend, lpre, md, ($urandom % 5 == 0), "R2 R3 R4 R5 R6 R7 R9 R10");
            prev = arr;
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule